// File: doc/BRIEF.md
# Multiplying Successive-Approximation Conversion Controller

This block is the digital sequencer of an 8-bit charge-redistribution converter that can also scale its input by a programmed coefficient. In the sampling clock it does not simply open every capacitor of the array. Each capacitor-enable line is gated by one bit of a coefficient mask, so the charge held on the array is proportional to the input times that coefficient. The following clocks run an ordinary binary search against a one-bit comparator, which produces the code of input × coefficient / 256. In raw mode every gate is open and the block acts as a plain converter.

A conversion always takes eleven controller clocks: one to sample, eight bit trials from the most significant bit down, one to latch the code into the output register, and one gap clock. The coefficient and two sign flags travel with each result, ready for two's-complement handling further on. They arrive through a serial shift port into a shadow register. A load strobe copies the shadow into the working copy, but only while no conversion is in progress. A strobe given during a conversion is held until the gap clock. While the run input stays high, conversions follow one another with no pause.

Top module: `msar_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cap_en`, `result`, `res_sign`, `done`, `busy` and `sample_ph` are all zero.
- R2: In the sampling clock with `raw_mode` low, `cap_en` equals the working coefficient mask, bit i of the mask gating capacitor i (1 enables, 0 disables).
- R3: In the sampling clock with `raw_mode` high, every bit of `cap_en` is 1, whatever the mask holds.
- R4: The bit trials run most significant first. The clock right after sampling drives `cap_en` = 8'h80. In each trial `cap_en` carries the bits decided so far plus the bit under test, and `cmp_in` = 1 keeps the tested bit.
- R5: With an array whose charge is vin·M/256, the latched code equals floor(vin·M/256), where M is the mask, or 255 in raw mode.
- R6: A conversion spans exactly 11 clocks. With `run` held high, `sample_ph` is high once every 11 clocks.
- R7: `done` is high for exactly one clock, the clock in which the new `result` first appears. `result` and `res_sign` do not change at any other time.
- R8: `res_sign` shows the two sign flags that were active during the conversion the result belongs to.
- R9: The serial port shifts in ten bits, the first bit going in first: sign[1], sign[0], then mask bits 7 down to 0. The load strobe takes effect only between conversions. A strobe given mid-conversion leaves that conversion unchanged and applies from the next sampling clock.
- R10: If `run` falls during a conversion, that conversion still completes. The block then returns to idle, with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start and keep converting while high |
| raw_mode | input | 1 | 1 opens all sampling gates (plain conversion) |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift_en | input | 1 | Shift `cfg_sdi` into the shadow register |
| cfg_load | input | 1 | Request copy of shadow into working configuration |
| cmp_in | input | 1 | Comparator decision, 1 = keep tested bit |
| cap_en | output | 8 | Capacitor-enable lines of the array |
| sample_ph | output | 1 | High during the sampling clock |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-clock pulse with a fresh result |
| result | output | 8 | Registered conversion code |
| res_sign | output | 2 | Sign flags accompanying the result |

## Verification
The bench builds the block with its default widths: an 8-bit code and two sign flags. With these widths it can compare every result exactly against the floor of vin·M/256, using a comparator model that reacts to `cap_en`. Its vectors cover full-scale and zero coefficients, alternating-bit masks, raw mode with a zero mask, and an input that stays below one LSB. A back-to-back run checks the 11-clock cadence. It also checks a strobe deferred across a conversion boundary and a stop that lets the last conversion finish.

// File: rtl/msar_pkg.sv
// Shared types for the multiplying SAR controller.
package msar_pkg;
    // Phases of one conversion; IDLE lies outside any conversion.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_TRIAL  = 3'd2,
        PH_LATCH  = 3'd3,
        PH_GAP    = 3'd4
    } msar_phase_e;
endpackage

// File: rtl/msar_cfg.sv
// Configuration holder: a serial shadow register and the working copy
// (coefficient mask plus sign flags). Assumes load_window is high only
// between conversions; a strobe outside the window is held pending.
module msar_cfg #(
    parameter int NBITS = 8,
    parameter int NSIGN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic             shift_en,
    input  logic             load_req,
    input  logic             load_window,
    output logic [NBITS-1:0] mask_q,
    output logic [NSIGN-1:0] sign_q
);
    localparam int W = NBITS + NSIGN;

    logic [W-1:0] shadow_q;
    logic         pend_q;

    // Shift the serial stream into the shadow, first bit ends at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shift_en) begin
            shadow_q <= {shadow_q[W-2:0], sdi};
        end
    end

    // Transfer shadow to working copy inside the window, else remember the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            mask_q <= '0;
            sign_q <= '0;
        end else if (load_window && (pend_q || load_req)) begin
            pend_q <= 1'b0;
            mask_q <= shadow_q[NBITS-1:0];
            sign_q <= shadow_q[W-1:NBITS];
        end else if (load_req) begin
            pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/msar_seq.sv
// Conversion sequencer: one sample clock, NBITS trials counting the bit
// index down, one latch clock and one gap clock. Assumes run is synchronous.
module msar_seq
    import msar_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output msar_phase_e     phase,
    output logic [IDXW-1:0] bit_idx
);
    localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NBITS - 1);

    // Advance the phase and bit index once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_idx <= '0;
        end else begin
            unique case (phase)
                PH_IDLE:   if (run) phase <= PH_SAMPLE;
                PH_SAMPLE: begin
                    phase   <= PH_TRIAL;
                    bit_idx <= TOP_IDX;
                end
                PH_TRIAL: begin
                    if (bit_idx == '0) phase <= PH_LATCH;
                    else               bit_idx <= bit_idx - 1'b1;
                end
                PH_LATCH:  phase <= PH_GAP;
                PH_GAP:    phase <= run ? PH_SAMPLE : PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msar_trial.sv
// Array drive and result path. In the sampling clock every capacitor is
// driven, gated by the coefficient (or forced open in raw mode); in the
// trials the decided bits plus the bit under test drive the array.
// Assumes cmp_in is valid at the end of each trial clock.
module msar_trial
    import msar_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int NSIGN = 2,
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  msar_phase_e      phase,
    input  logic [IDXW-1:0]  bit_idx,
    input  logic             cmp_in,
    input  logic             raw_mode,
    input  logic [NBITS-1:0] mask,
    input  logic [NSIGN-1:0] sign,
    output logic [NBITS-1:0] cap_en,
    output logic [NBITS-1:0] result,
    output logic [NSIGN-1:0] res_sign,
    output logic             done
);
    logic [NBITS-1:0] decided_q;
    logic [NBITS-1:0] drive;
    logic [NBITS-1:0] gate;

    // Clear decisions at sampling, record the comparator in each trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decided_q <= '0;
        end else if (phase == PH_SAMPLE) begin
            decided_q <= '0;
        end else if (phase == PH_TRIAL) begin
            decided_q[bit_idx] <= cmp_in;
        end
    end

    // Output register: capture code and signs, pulse done once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            res_sign <= '0;
            done     <= 1'b0;
        end else if (phase == PH_LATCH) begin
            result   <= decided_q;
            res_sign <= sign;
            done     <= 1'b1;
        end else begin
            done     <= 1'b0;
        end
    end

    // Compose the drive bits and the sampling gate for the array.
    always_comb begin
        gate  = raw_mode ? {NBITS{1'b1}} : mask;
        drive = '0;
        unique case (phase)
            PH_SAMPLE: drive = {NBITS{1'b1}};
            PH_TRIAL:  drive = decided_q | (NBITS'(1) << bit_idx);
            default:   drive = '0;
        endcase
        cap_en = (phase == PH_SAMPLE) ? (drive & gate) : drive;
    end
endmodule

// File: rtl/msar_ctrl.sv
// Top of the multiplying SAR controller: ties configuration, sequencer and
// trial/result path together. Assumes all inputs are synchronous to clk.
module msar_ctrl
    import msar_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int NSIGN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             raw_mode,
    input  logic             cfg_sdi,
    input  logic             cfg_shift_en,
    input  logic             cfg_load,
    input  logic             cmp_in,
    output logic [NBITS-1:0] cap_en,
    output logic             sample_ph,
    output logic             busy,
    output logic             done,
    output logic [NBITS-1:0] result,
    output logic [NSIGN-1:0] res_sign
);
    localparam int IDXW = (NBITS > 1) ? $clog2(NBITS) : 1;

    msar_phase_e      phase;
    logic [IDXW-1:0]  bit_idx;
    logic [NBITS-1:0] mask_act;
    logic [NSIGN-1:0] sign_act;
    logic             load_window;

    // Configuration may change only outside a conversion or in its gap clock.
    assign load_window = (phase == PH_IDLE) || (phase == PH_GAP);
    assign sample_ph   = (phase == PH_SAMPLE);
    assign busy        = (phase != PH_IDLE);

    msar_cfg #(.NBITS(NBITS), .NSIGN(NSIGN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .sdi(cfg_sdi), .shift_en(cfg_shift_en),
        .load_req(cfg_load), .load_window(load_window),
        .mask_q(mask_act), .sign_q(sign_act)
    );

    msar_seq #(.NBITS(NBITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .bit_idx(bit_idx)
    );

    msar_trial #(.NBITS(NBITS), .NSIGN(NSIGN)) u_trial (
        .clk(clk), .rst_n(rst_n), .phase(phase), .bit_idx(bit_idx),
        .cmp_in(cmp_in), .raw_mode(raw_mode), .mask(mask_act), .sign(sign_act),
        .cap_en(cap_en), .result(result), .res_sign(res_sign), .done(done)
    );
endmodule

// File: rtl/msar_ctrl_chk.sv
// Checker for msar_ctrl, attached by bind; observes ports only.
module msar_ctrl_chk #(
    parameter int NBITS = 8,
    parameter int NSIGN = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raw_mode,
    input logic             sample_ph,
    input logic             busy,
    input logic             done,
    input logic [NBITS-1:0] cap_en,
    input logic [NBITS-1:0] result,
    input logic [NSIGN-1:0] res_sign
);
    // R3: raw sampling opens every gate.
    p_raw_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_ph && raw_mode) |-> (cap_en == {NBITS{1'b1}}));

    // R4: the first trial tests only the most significant bit.
    p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ph |=> (cap_en == (NBITS'(1) << (NBITS - 1))));

    // R6: sampling never lasts two clocks in a row.
    p_single_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ph |=> !sample_ph);

    // R7: done is a single-clock pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result only moves together with done.
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R8: sign flags only move together with done.
    p_sign_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_sign));

    // R10: an idle controller drives no capacitor.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cap_en == '0));
endmodule

bind msar_ctrl msar_ctrl_chk #(.NBITS(NBITS), .NSIGN(NSIGN)) u_chk (
    .clk(clk), .rst_n(rst_n), .raw_mode(raw_mode), .sample_ph(sample_ph),
    .busy(busy), .done(done), .cap_en(cap_en), .result(result),
    .res_sign(res_sign)
);

// File: tb/msar_ctrl_test.sv
`timescale 1ns/1ps
module msar_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       raw_mode = 1'b0;
    logic       cfg_sdi = 1'b0;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cmp_in;
    logic [7:0] cap_en;
    logic       sample_ph, busy, done;
    logic [7:0] result;
    logic [1:0] res_sign;

    logic [7:0] vin = 8'd0;
    logic [7:0] msamp = 8'd0;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    msar_ctrl uut (
        .clk(clk), .rst_n(rst_n), .run(run), .raw_mode(raw_mode),
        .cfg_sdi(cfg_sdi), .cfg_shift_en(cfg_shift_en), .cfg_load(cfg_load),
        .cmp_in(cmp_in), .cap_en(cap_en), .sample_ph(sample_ph), .busy(busy),
        .done(done), .result(result), .res_sign(res_sign)
    );

    // Behavioural array and comparator: charge vin*M/256 against trial level.
    always_comb cmp_in = ((32'(vin) * 32'(msamp)) >= (32'(cap_en) << 8));

    // Vector: {raw, vin[7:0], mask[7:0], sign[1:0]}
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 8'd200, 8'h80, 2'b01},
        {1'b0, 8'd255, 8'hFF, 2'b10},
        {1'b0, 8'd100, 8'h00, 2'b11},
        {1'b0, 8'd37,  8'h55, 2'b00},
        {1'b1, 8'd173, 8'h00, 2'b10},
        {1'b1, 8'd0,   8'h3C, 2'b01},
        {1'b0, 8'd255, 8'h01, 2'b11},
        {1'b0, 8'd129, 8'hAA, 2'b01}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_code(input int v, input int m);
        return (v * m) / 256;
    endfunction

    // Shift sign[1], sign[0], mask[7..0] into the shadow register.
    task automatic send_cfg(input logic [1:0] s, input logic [7:0] m);
        logic [9:0] word;
        word = {s, m};
        for (int i = 9; i >= 0; i--) begin
            cfg_sdi = word[i];
            cfg_shift_en = 1'b1;
            tick();
        end
        cfg_shift_en = 1'b0;
    endtask

    task automatic pulse_load();
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    // One isolated conversion with full checking.
    task automatic do_conv(input logic raw, input logic [7:0] v,
                           input logic [7:0] m, input logic [1:0] s);
        int em;
        int ec;
        send_cfg(s, m);
        pulse_load();
        raw_mode = raw;
        vin = v;
        em = raw ? 255 : int'(m);
        ec = expect_code(int'(v), em);
        run = 1'b1;
        tick();
        run = 1'b0;
        msamp = cap_en;
        chk(sample_ph == 1'b1, "R6 sample phase", int'(sample_ph), 1);
        if (raw) chk(cap_en == 8'hFF, "R3 raw gates open", int'(cap_en), 255);
        else     chk(cap_en == m, "R2 sample mask", int'(cap_en), int'(m));
        tick();
        chk(cap_en == 8'h80, "R4 msb first", int'(cap_en), 128);
        repeat (9) tick();
        chk(done == 1'b1, "R7 done pulse", int'(done), 1);
        chk(result == 8'(ec), "R5 code", int'(result), ec);
        chk(res_sign == s, "R8 signs", int'(res_sign), int'(s));
        tick();
        chk(done == 1'b0, "R7 done ends", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ea;
        int eb;
        int nsamp;
        repeat (3) tick();
        chk(cap_en == 8'h00, "R1 cap_en reset", int'(cap_en), 0);
        chk(result == 8'h00, "R1 result reset", int'(result), 0);
        chk(done == 1'b0 && busy == 1'b0 && sample_ph == 1'b0, "R1 flags reset",
            int'({done, busy, sample_ph}), 0);
        rst_n = 1'b1;
        tick();
        chk(busy == 1'b0 && res_sign == 2'b00, "R1 idle after reset",
            int'({busy, res_sign}), 0);

        foreach (VEC[k]) begin
            do_conv(VEC[k][18], VEC[k][17:10], VEC[k][9:2], VEC[k][1:0]);
        end

        // Back-to-back run: cadence, deferred load, stop mid-conversion.
        send_cfg(2'b01, 8'h40);
        pulse_load();
        send_cfg(2'b10, 8'hF0);
        raw_mode = 1'b0;
        vin = 8'd250;
        ea = expect_code(250, 8'h40);
        eb = expect_code(250, 8'hF0);
        run = 1'b1;
        tick();
        msamp = cap_en;
        chk(cap_en == 8'h40, "R9 first conversion mask", int'(cap_en), 64);
        nsamp = 0;
        for (int t = 1; t <= 22; t++) begin
            tick();
            if (t == 3) begin
                cfg_load = 1'b1;
            end else begin
                cfg_load = 1'b0;
            end
            if (t <= 10 && sample_ph) nsamp++;
            if (t == 10) begin
                chk(nsamp == 0, "R6 no early sample", nsamp, 0);
                chk(result == 8'(ea), "R9 mid load no effect", int'(result), ea);
                chk(res_sign == 2'b01, "R8 first signs", int'(res_sign), 1);
            end
            if (t == 11) begin
                msamp = cap_en;
                chk(sample_ph == 1'b1, "R6 eleven clock period", int'(sample_ph), 1);
                chk(cap_en == 8'hF0, "R9 deferred load applied", int'(cap_en), 240);
            end
            if (t == 12) run = 1'b0;
            if (t == 21) begin
                chk(done == 1'b1, "R10 last conversion done", int'(done), 1);
                chk(result == 8'(eb), "R5 second code", int'(result), eb);
                chk(res_sign == 2'b10, "R8 second signs", int'(res_sign), 2);
            end
            if (t == 22) begin
                chk(busy == 1'b0 && done == 1'b0, "R10 idle after stop",
                    int'({busy, done}), 0);
            end
        end
        repeat (5) tick();
        chk(sample_ph == 1'b0 && cap_en == 8'h00, "R10 stays idle",
            int'({sample_ph, cap_en}), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule